// File: doc/BRIEF.md
# Non-Maskable Interrupt Request and Flag Register

This block watches an external non-maskable interrupt pin and turns each rising edge into two independent records. The first is a pending request line to the CPU, which stays high until the CPU signals that it has taken the exception. The second is a sticky flag that software reads through a 32-bit status and control word. Only software can clear this flag. The two records share a detection event and nothing else. Acknowledging the request leaves the flag alone, and clearing the flag leaves a pending request in place.

The pin is asynchronous. It passes through a synchronizer chain before edge detection. The synchronized level is also shown live in the top bit of the status word. Reads are combinational when the register is selected, and return zero otherwise. A write carries one meaningful bit. A 0 in the flag position clears the flag, and every other written bit is ignored.

Top module: `nmi_flag_ctrl`

## Requirements
- R1: Bit 31 of the read word equals the pin level after two synchronizer clocks: a pin change applied before clock edge k shows at bit 31 after edge k+1. Writes to bit 31 have no effect.
- R2: Read bits 30 to 16 and 14 to 0 always return 0, whatever was written.
- R3: A low-to-high pin transition sets the flag (bit 15) and the request output after the third clock edge following the pin change. A pin held high causes no further detection.
- R4: A register write with bit 15 equal to 0 clears the flag on the next edge. A write with bit 15 equal to 1 leaves it as it was.
- R5: The request output falls on the edge after the CPU acknowledge input is high, and the acknowledge never changes the flag.
- R6: Clearing the flag by software never cancels a pending request. The request stays high until it is acknowledged.
- R7: When a detection and a software clear of the flag fall in the same cycle, the flag ends up set.
- R8: When a detection and an acknowledge fall in the same cycle, the request stays set.
- R9: After reset the flag, the request and the synchronizer state are 0.
- R10: With the register not selected, the read data is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| nmi_pin | input | 1 | Asynchronous non-maskable interrupt pin |
| cpu_ack | input | 1 | CPU has accepted the pending NMI |
| reg_sel | input | 1 | Register selected for access |
| reg_wr | input | 1 | Write strobe (valid with reg_sel) |
| reg_wdata | input | 32 | Write data, bit 15 is the flag clear bit |
| reg_rdata | output | 32 | Read data |
| nmi_req | output | 1 | Pending NMI request to the CPU |

## Verification
The bench aims at the cycles where two events meet. A detection can coincide with a software clear of the flag. If the design gave the clear priority, that NMI would be lost from the flag. A detection can also coincide with an acknowledge. If the acknowledge won, the CPU would miss the second NMI. Other directed cases clear the flag while a request is pending and acknowledge while the flag is set. A design that coupled the two records would drop one of them there. Random pin, acknowledge and write traffic is compared every cycle against a bench model, and it catches wrong latency, a level-sensitive detector that re-triggers, and leakage into the reserved bits.

// File: rtl/nmi_flag_pkg.sv
package nmi_flag_pkg;
    localparam int REG_W    = 32;
    localparam int LVL_BIT  = 31;
    localparam int FLAG_BIT = 15;
    localparam int SYNC_N   = 2;

    typedef struct packed {
        logic req;
    } req_state_t;

    typedef struct packed {
        logic flag;
    } flag_state_t;
endpackage

// File: rtl/nmi_pin_sync.sv
module nmi_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    output logic level_o,
    output logic rise_o
);
    typedef struct packed {
        logic [STAGES-1:0] chain;
        logic              prev;
    } sync_state_t;

    sync_state_t st_d, st_q;

    always_comb begin
        st_d          = st_q;
        st_d.chain[0] = pin_i;
        for (int i = 1; i < STAGES; i++) begin
            st_d.chain[i] = st_q.chain[i-1];
        end
        st_d.prev     = st_q.chain[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign level_o = st_q.chain[STAGES-1];
    assign rise_o  = st_q.chain[STAGES-1] & ~st_q.prev;

    // R3: a detect pulse is a single cycle
    assert_rise_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rise_o |=> !rise_o);
endmodule

// File: rtl/nmi_req_latch.sv
module nmi_req_latch
    import nmi_flag_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic det_i,
    input  logic ack_i,
    output logic req_o
);
    req_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (ack_i) st_d.req = 1'b0;
        if (det_i) st_d.req = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign req_o = st_q.req;

    assert_req_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_o && !ack_i) |=> req_o);
    assert_req_ack_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && !det_i) |=> !req_o);
    assert_det_beats_ack_R8: assert property (@(posedge clk) disable iff (!rst_n)
        det_i |=> req_o);
endmodule

// File: rtl/nmi_flag_reg.sv
module nmi_flag_reg
    import nmi_flag_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             det_i,
    input  logic             level_i,
    input  logic             sel_i,
    input  logic             wr_i,
    input  logic             wflag_i,
    output logic [REG_W-1:0] rdata_o
);
    flag_state_t st_d, st_q;
    logic        sw_clr;

    assign sw_clr = sel_i & wr_i & ~wflag_i;

    always_comb begin
        st_d = st_q;
        if (sw_clr) st_d.flag = 1'b0;
        if (det_i)  st_d.flag = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        rdata_o = '0;
        if (sel_i) begin
            rdata_o[LVL_BIT]  = level_i;
            rdata_o[FLAG_BIT] = st_q.flag;
        end
    end

    assert_flag_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
        det_i |=> st_q.flag);
    assert_flag_fall_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(st_q.flag) |-> $past(sw_clr));
endmodule

// File: rtl/nmi_flag_ctrl.sv
module nmi_flag_ctrl
    import nmi_flag_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             nmi_pin,
    input  logic             cpu_ack,
    input  logic             reg_sel,
    input  logic             reg_wr,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    output logic             nmi_req
);
    logic level, rise;
    logic unused_wbits;

    assign unused_wbits = &{1'b0, reg_wdata};

    nmi_pin_sync #(.STAGES(SYNC_N)) u_sync (
        .clk(clk), .rst_n(rst_n), .pin_i(nmi_pin),
        .level_o(level), .rise_o(rise)
    );

    nmi_req_latch u_req (
        .clk(clk), .rst_n(rst_n), .det_i(rise), .ack_i(cpu_ack),
        .req_o(nmi_req)
    );

    nmi_flag_reg u_flag (
        .clk(clk), .rst_n(rst_n), .det_i(rise), .level_i(level),
        .sel_i(reg_sel), .wr_i(reg_wr), .wflag_i(reg_wdata[FLAG_BIT]),
        .rdata_o(reg_rdata)
    );

    // R2 / R10: reserved positions and unselected reads stay zero
    assert_rsvd_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rdata & ~((32'h1 << LVL_BIT) | (32'h1 << FLAG_BIT))) == '0);
    assert_unsel_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_sel |-> (reg_rdata == '0));
endmodule

// File: tb/nmi_flag_ctrl_tb.sv
module nmi_flag_ctrl_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        nmi_pin = 1'b0, cpu_ack = 1'b0, reg_sel = 1'b0, reg_wr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        nmi_req;

    int errors = 0;
    int checks = 0;

    // bench model of the requirements
    logic m1 = 0, m2 = 0, m3 = 0, mreq = 0, mflag = 0;

    always #10 clk = ~clk; // 50 MHz

    nmi_flag_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .nmi_pin(nmi_pin), .cpu_ack(cpu_ack),
        .reg_sel(reg_sel), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .nmi_req(nmi_req)
    );

    function automatic logic [31:0] exp_read(logic sel, logic lvl, logic flg);
        logic [31:0] v = '0;
        if (sel) begin
            v[31] = lvl;
            v[15] = flg;
        end
        return v;
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // one cycle: drive at negedge, check, advance model at posedge
    task automatic cyc(string tag, logic pin, logic ack, logic sel, logic wr, logic [31:0] wd);
        logic det;
        nmi_pin = pin; cpu_ack = ack; reg_sel = sel; reg_wr = wr; reg_wdata = wd;
        #1;
        check({tag, " R1 R2 R10 rdata"}, reg_rdata, exp_read(sel, m2, mflag));
        check({tag, " R3 R5 R6 req"}, {31'b0, nmi_req}, {31'b0, mreq});
        @(posedge clk);
        det = m2 & ~m3;
        mreq  = det | (mreq & ~ack);
        mflag = det | (mflag & ~(sel & wr & ~wd[15]));
        m3 = m2; m2 = m1; m1 = pin;
        @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        // R9: reset state
        reg_sel = 1'b1; #1;
        check("R9 reset rdata", reg_rdata & 32'h0000_8000, 32'h0);
        check("R9 reset req", {31'b0, nmi_req}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);

        // R3: rise sets both, latency three edges; held high no retrigger
        cyc("R3 rise", 1, 0, 1, 0, 0);
        cyc("R3 wait", 1, 0, 1, 0, 0);
        cyc("R3 wait", 1, 0, 1, 0, 0);
        check("R3 flag set", reg_rdata & 32'h8000, 32'h8000);
        check("R3 req set", {31'b0, nmi_req}, 32'h1);
        // R4: write 1 keeps, write 0 clears; R6 request survives; R1 bit31 ignores writes
        cyc("R4 wr1", 1, 0, 1, 1, 32'hFFFF_FFFF);
        cyc("R6 wr0", 1, 0, 1, 1, 32'h7FFF_0000);
        check("R4 flag cleared", reg_rdata & 32'h8000, 32'h0);
        check("R6 req kept", {31'b0, nmi_req}, 32'h1);
        check("R1 level high", reg_rdata & 32'h8000_0000, 32'h8000_0000);
        cyc("R3 held", 1, 0, 1, 0, 0);
        cyc("R3 held", 1, 0, 1, 0, 0);
        check("R3 no retrigger", reg_rdata & 32'h8000, 32'h0);
        // R5: ack clears request
        cyc("R5 ack", 1, 1, 1, 0, 0);
        check("R5 req dropped", {31'b0, nmi_req}, 32'h0);

        // R5: ack leaves flag; new event first
        cyc("R5 low", 0, 0, 1, 0, 0);
        cyc("R5 low", 0, 0, 1, 0, 0);
        cyc("R5 low", 0, 0, 1, 0, 0);
        cyc("R5 rise", 1, 0, 1, 0, 0);
        cyc("R5 w", 1, 0, 1, 0, 0);
        cyc("R5 w", 1, 0, 1, 0, 0);
        cyc("R5 ack", 1, 1, 1, 0, 0);
        check("R5 flag kept after ack", reg_rdata & 32'h8000, 32'h8000);

        // R7 and R8: detection coincides with clear and ack (detect high after 2 edges)
        cyc("R8 low", 0, 0, 1, 0, 0);
        cyc("R8 low", 0, 0, 1, 0, 0);
        cyc("R8 low", 0, 1, 1, 1, 0);
        cyc("R8 rise", 1, 0, 1, 0, 0);
        cyc("R8 w", 1, 0, 1, 0, 0);
        cyc("R7 R8 meet", 1, 1, 1, 1, 0);
        check("R7 set beats clear", reg_rdata & 32'h8000, 32'h8000);
        check("R8 detect beats ack", {31'b0, nmi_req}, 32'h1);
        cyc("R10 unsel", 1, 0, 0, 0, 0);

        // random traffic
        for (int i = 0; i < 3000; i++) begin
            logic p, a, s, w;
            logic [31:0] d;
            p = ($urandom % 5) < 2 ? ~nmi_pin : nmi_pin;
            a = ($urandom % 4) == 0;
            s = ($urandom % 4) != 0;
            w = ($urandom % 3) == 0;
            d = $urandom;
            cyc("RND", p, a, s, w, d);
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule